// File: doc/BRIEF.md
# Conversion Mode Sequencer

This block decides when the converter of a delta-sigma ADC is running. It watches writes to the configuration fields that pick the operating mode, the start request, the output rate and the power-down request. It then times each conversion with a timebase tick that stands in for the modulator, so each tick is one modulator step. There are two operating modes. In single-shot mode, one start request gives one result, after which the block goes back to sleep. In continuous mode, conversions run back to back until something stops them.

The conversion period comes from the selected rate and is counted in ticks. In single-shot mode, the number of filter periods a result needs depends on the order of the decimation filter that the rate implies: slow rates use a third-order filter and fast rates use a fourth-order filter. The block reports a busy/idle status in the form the start bit reads back, and it gives a one-cycle strobe when a result is ready. The filter arithmetic and the modulator itself are not part of this block.

Top module: `conv_mode_seq`

## Requirements
- R1: After a synchronous reset, os_status is 1, result_valid is 0, single-shot mode (mode value 1) is selected and no conversion is running.
- R2: In single-shot mode with the block idle, a configuration write with cfg_mode=1 and cfg_os=1 starts a conversion, and os_status reads 0 from the next cycle on. The same write with cfg_os=0 starts nothing.
- R3: During a single-shot conversion, a configuration write that keeps cfg_mode=1 is ignored. The result arrives on its original cycle, even when the write lands on the completing cycle itself.
- R4: When a single-shot conversion ends, result_valid is high for exactly one cycle and os_status returns to 1 in that same cycle. No further result appears until the next start.
- R5: A single-shot conversion lasts 3 filter periods for rate codes 0 to 4 and 4 filter periods for rate codes 5 to 7. With a tick on every cycle, result_valid appears P*N cycles after the clock edge that took the start write.
- R6: A period is P = 4*TICK_HZ/(25*2^code) ticks when cfg1_rate_alt=0 and P = 4*TICK_HZ/(30*2^code) ticks when cfg1_rate_alt=1. Only cycles with tick=1 count.
- R7: A configuration write with cfg_mode=0 starts continuous mode. After that, result_valid pulses once every P ticks and os_status stays 0.
- R8: A write with cfg1_pd=1 stops any conversion. No result is given, and os_status is 1 on the next cycle, even if a result would have completed in that same cycle. The request clears itself, so a later start needs no further write.
- R9: A configuration write that changes the mode value aborts the running conversion without a result. New mode 0 starts a fresh continuous run. New mode 1 starts a fresh single-shot if cfg_os=1 and otherwise leaves the block idle.
- R10: A rate code or rate table select written during a conversion without a mode change takes effect at the next conversion start or the next continuous period. The period and the filter order are captured at each start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase tick, one per modulator step |
| cfg_wr | input | 1 | Strobe: configuration register write |
| cfg_mode | input | 1 | Mode value written: 0 continuous, 1 single-shot |
| cfg_os | input | 1 | Start-request bit written with the configuration |
| cfg_rate | input | 3 | Rate code written |
| cfg1_wr | input | 1 | Strobe: second configuration register write |
| cfg1_rate_alt | input | 1 | Rate table select: 0 for the 6.25 to 800 SPS table, 1 for the 7.5 to 960 SPS table |
| cfg1_pd | input | 1 | Power-down request, self-clearing |
| os_status | output | 1 | Start-bit readback: 1 idle, 0 converting |
| result_valid | output | 1 | One-cycle strobe: result ready |

## Verification
Two functions can fall on the same cycle: the completion of a single-shot conversion, and a register write that arrives exactly on the tick that finishes the last filter period. The bench places a start write, and separately a power-down write, on that cycle. To find it, it counts the cycles from the start write using the known period count. The start write must leave the result on time and must not restart anything afterwards. The power-down write must suppress the result altogether. A cycle-by-cycle behavioural model judges both cases, along with the latency counts.

// File: rtl/cms_pkg.sv
package cms_pkg;

  typedef enum logic {
    MODE_CONT   = 1'b0,
    MODE_SINGLE = 1'b1
  } conv_mode_e;

  localparam int unsigned RATE_W     = 3;
  localparam int unsigned RATE_CODES = 1 << RATE_W;
  localparam logic [RATE_W-1:0] RST_RATE   = 3'd4;
  localparam logic [RATE_W-1:0] FOURTH_MIN = 3'd5;

  // Ticks per output period; idx = {table select, rate code}.
  function automatic int unsigned period_of(int unsigned hz, int unsigned idx);
    int unsigned base;
    base = (idx >= RATE_CODES) ? 30 : 25;
    return (hz * 4) / (base << (idx % RATE_CODES));
  endfunction

endpackage

// File: rtl/cms_rate_lut.sv
module cms_rate_lut
  import cms_pkg::*;
#(
  parameter int unsigned TICK_HZ = 19200,
  parameter int unsigned CNT_W   = 12
) (
  input  logic              rate_alt,
  input  logic [RATE_W-1:0] rate,
  output logic [CNT_W-1:0]  period,
  output logic              fourth
);

  localparam int unsigned N_ENT = 2 * RATE_CODES;

  logic [CNT_W-1:0] tbl [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign tbl[i] = CNT_W'(period_of(TICK_HZ, i));
  end

  assign period = tbl[{rate_alt, rate}];
  assign fourth = (rate >= FOURTH_MIN);

endmodule

// File: rtl/cms_tick_timer.sv
module cms_tick_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] start_period,
  input  logic             run,
  input  logic             tick,
  output logic             period_end
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;

  assign period_end = run && tick && (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      per_q <= start_period;
    end else if (run && tick) begin
      cnt_q <= period_end ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
  import cms_pkg::*;
#(
  parameter int unsigned TICK_HZ = 19200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        cfg_wr,
  input  logic        cfg_mode,
  input  logic        cfg_os,
  input  logic [2:0]  cfg_rate,
  input  logic        cfg1_wr,
  input  logic        cfg1_rate_alt,
  input  logic        cfg1_pd,
  output logic        os_status,
  output logic        result_valid
);

  localparam int unsigned MAX_PERIOD = (TICK_HZ * 4) / 25;
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);

  conv_mode_e        mode_q;
  logic [RATE_W-1:0] rate_q;
  logic              alt_q;
  logic              active_q;
  logic              ord4_q;
  logic [1:0]        fcnt_q;
  logic              rv_q;

  logic [RATE_W-1:0] eff_rate;
  logic              eff_alt;
  logic [CNT_W-1:0]  lut_period;
  logic              lut_fourth;
  logic              pend;
  logic              pd_hit, mode_chg, can_act, start_wr, start_cont, start;
  logic              last_period, active_d, rv_d;

  // Values written in this cycle steer a start in the same cycle.
  assign eff_rate = cfg_wr  ? cfg_rate      : rate_q;
  assign eff_alt  = cfg1_wr ? cfg1_rate_alt : alt_q;

  cms_rate_lut #(.TICK_HZ(TICK_HZ), .CNT_W(CNT_W)) u_lut (
    .rate_alt (eff_alt),
    .rate     (eff_rate),
    .period   (lut_period),
    .fourth   (lut_fourth)
  );

  cms_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_period (lut_period),
    .run          (active_q),
    .tick         (tick),
    .period_end   (pend)
  );

  always_comb begin
    pd_hit      = cfg1_wr && cfg1_pd;
    mode_chg    = cfg_wr && (conv_mode_e'(cfg_mode) != mode_q);
    can_act     = cfg_wr && !pd_hit && (mode_chg || !active_q);
    start_wr    = can_act && ((cfg_mode == MODE_CONT) || cfg_os);
    start_cont  = active_q && (mode_q == MODE_CONT) && pend && !pd_hit && !mode_chg;
    start       = start_wr || start_cont;
    last_period = (mode_q == MODE_CONT) || (fcnt_q == (ord4_q ? 2'd3 : 2'd2));
    rv_d        = pend && last_period && !pd_hit && !mode_chg;

    if (pd_hit)
      active_d = 1'b0;
    else if (start)
      active_d = 1'b1;
    else if (mode_chg)
      active_d = 1'b0;
    else if (active_q && pend && last_period && (mode_q == MODE_SINGLE))
      active_d = 1'b0;
    else
      active_d = active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_SINGLE;
      rate_q   <= RST_RATE;
      alt_q    <= 1'b0;
      active_q <= 1'b0;
      ord4_q   <= 1'b0;
      fcnt_q   <= '0;
      rv_q     <= 1'b0;
    end else begin
      if (cfg_wr) begin
        mode_q <= conv_mode_e'(cfg_mode);
        rate_q <= cfg_rate;
      end
      if (cfg1_wr) alt_q <= cfg1_rate_alt;
      active_q <= active_d;
      rv_q     <= rv_d;
      if (start) begin
        fcnt_q <= '0;
        ord4_q <= lut_fourth;
      end else if (pend) begin
        fcnt_q <= fcnt_q + 2'd1;
      end
    end
  end

  assign os_status    = !active_q;
  assign result_valid = rv_q;

endmodule

// File: rtl/conv_mode_seq_chk.sv
module conv_mode_seq_chk (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic cfg_mode,
  input logic cfg_os,
  input logic cfg1_wr,
  input logic cfg1_pd,
  input logic os_status,
  input logic result_valid,
  input logic mode_q
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid); // R4

  AST_RESULT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $past(!os_status)); // R4

  AST_SINGLE_RESULT_IDLES: assert property (@(posedge clk) disable iff (rst)
    (result_valid && mode_q) |-> os_status); // R4

  AST_OS_START: assert property (@(posedge clk) disable iff (rst)
    (os_status && cfg_wr && cfg_os && cfg_mode && !cfg1_wr) |=> !os_status); // R2

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!os_status && mode_q && cfg_wr && cfg_mode && !(cfg1_wr && cfg1_pd))
      |=> (!os_status || result_valid)); // R3

  AST_PD_STOPS: assert property (@(posedge clk) disable iff (rst)
    (cfg1_wr && cfg1_pd) |=> (os_status && !result_valid)); // R8

  AST_MODE_SWITCH_ABORT: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_mode != mode_q)) |=> !result_valid); // R9

  AST_CONT_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (!os_status && !mode_q && !cfg_wr && !cfg1_wr) |=> !os_status); // R7

endmodule

bind conv_mode_seq conv_mode_seq_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_wr       (cfg_wr),
  .cfg_mode     (cfg_mode),
  .cfg_os       (cfg_os),
  .cfg1_wr      (cfg1_wr),
  .cfg1_pd      (cfg1_pd),
  .os_status    (os_status),
  .result_valid (result_valid),
  .mode_q       (mode_q)
);

// File: tb/conv_mode_seq_tb.sv
`timescale 1ns/1ps
module conv_mode_seq_tb;

  localparam int TICK_HZ = 19200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_wr = 1'b0, cfg_mode = 1'b1, cfg_os = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic       cfg1_wr = 1'b0, cfg1_rate_alt = 1'b0, cfg1_pd = 1'b0;
  logic       os_status, result_valid;

  conv_mode_seq #(.TICK_HZ(TICK_HZ)) u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_os(cfg_os), .cfg_rate(cfg_rate),
    .cfg1_wr(cfg1_wr), .cfg1_rate_alt(cfg1_rate_alt), .cfg1_pd(cfg1_pd),
    .os_status(os_status), .result_valid(result_valid)
  );

  int    checks = 0, fails = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;
  bit    gap_mode = 1'b0;

  function automatic int per(int alt, int code);
    return (TICK_HZ * 4) / ((alt != 0 ? 30 : 25) * (1 << code));
  endfunction

  function automatic int ord(int code);
    return (code >= 5) ? 4 : 3;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: remaining-tick countdown per conversion.
  int m_busy = 0, m_mode = 1, m_rate = 4, m_alt = 0, m_rem = 0, m_rv = 0;

  always @(posedge clk) begin : model
    int er, ea;
    bit pd, mchg;
    if (rst) begin
      m_busy = 0; m_mode = 1; m_rate = 4; m_alt = 0; m_rem = 0; m_rv = 0;
    end else begin
      m_rv = 0;
      er   = cfg_wr  ? int'(cfg_rate)      : m_rate;
      ea   = cfg1_wr ? int'(cfg1_rate_alt) : m_alt;
      pd   = cfg1_wr && cfg1_pd;
      mchg = cfg_wr && (int'(cfg_mode) != m_mode);
      if (pd) begin
        m_busy = 0;
      end else if (cfg_wr && (mchg || m_busy == 0)) begin
        if (cfg_mode == 1'b0 || cfg_os) begin
          m_busy = 1;
          m_rem  = per(ea, er) * ((cfg_mode == 1'b0) ? 1 : ord(er));
        end else begin
          m_busy = 0;
        end
      end else if (m_busy != 0 && tick) begin
        m_rem--;
        if (m_rem == 0) begin
          m_rv = 1;
          if (m_mode == 0) m_rem = per(ea, er);
          else             m_busy = 0;
        end
      end
      if (cfg_wr) begin m_mode = int'(cfg_mode); m_rate = int'(cfg_rate); end
      if (cfg1_wr) m_alt = int'(cfg1_rate_alt);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(os_status === (m_busy == 0), phase, "os_status", int'(os_status), int'(m_busy == 0));
      chk(result_valid === (m_rv != 0), phase, "result_valid", int'(result_valid), m_rv);
    end
  end

  always @(negedge clk) tick <= gap_mode ? ~tick : 1'b1;

  task automatic cfg(input bit m, input bit os, input logic [2:0] r);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = m; cfg_os = os; cfg_rate = r;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_os = 1'b0;
  endtask

  task automatic cfg1(input bit alt, input bit pd);
    @(negedge clk);
    cfg1_wr = 1'b1; cfg1_rate_alt = alt; cfg1_pd = pd;
    @(negedge clk);
    cfg1_wr = 1'b0; cfg1_pd = 1'b0;
  endtask

  task automatic wait_rv(output int n, input int limit);
    n = 1;
    while (!result_valid && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic next_gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid && n < 5000);
  endtask

  task automatic idle_for(input int cyc, input string tag);
    bit seen;
    seen = 1'b0;
    repeat (cyc) begin
      @(negedge clk);
      if (result_valid) seen = 1'b1;
    end
    chk(!seen, tag, "no result while idle", int'(seen), 0);
    chk(os_status === 1'b1, tag, "os_status idle", int'(os_status), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk(os_status === 1'b1, "R1", "os_status after reset", int'(os_status), 1);
    chk(result_valid === 1'b0, "R1", "result_valid after reset", int'(result_valid), 0);

    // R2: OS=0 write starts nothing; OS=1 starts.
    phase = "R2";
    cfg(1'b1, 1'b0, 3'd7);
    idle_for(200, "R2");
    cfg(1'b1, 1'b1, 3'd7);
    chk(os_status === 1'b0, "R2", "busy after start", int'(os_status), 0);
    phase = "R5";
    wait_rv(n, 2000);
    chk(n == per(0, 7) * 4 + 1, "R5", "latency code7 tbl0", n, per(0, 7) * 4 + 1);
    @(negedge clk);
    phase = "R4";
    chk(result_valid === 1'b0, "R4", "strobe one cycle", int'(result_valid), 0);
    idle_for(100, "R4");

    // R5: third-order count at code 4, fourth at code 5.
    phase = "R5";
    cfg1(1'b1, 1'b0);
    cfg(1'b1, 1'b1, 3'd4);
    wait_rv(n, 3000);
    chk(n == per(1, 4) * 3 + 1, "R5", "latency code4 tbl1", n, per(1, 4) * 3 + 1);
    cfg1(1'b0, 1'b0);
    cfg(1'b1, 1'b1, 3'd5);
    wait_rv(n, 3000);
    chk(n == per(0, 5) * 4 + 1, "R5", "latency code5 tbl0", n, per(0, 5) * 4 + 1);

    // R3: OS write mid-conversion ignored.
    phase = "R3";
    cfg1(1'b1, 1'b0);
    cfg(1'b1, 1'b1, 3'd7);
    n = 1;
    while (!result_valid && n < 2000) begin
      @(negedge clk);
      n++;
      cfg_wr = (n == 30); cfg_os = (n == 30);
    end
    cfg_wr = 1'b0; cfg_os = 1'b0;
    chk(n == per(1, 7) * 4 + 1, "R3", "latency with busy write", n, per(1, 7) * 4 + 1);

    // R3: OS write on the completing cycle.
    cfg(1'b1, 1'b1, 3'd7);
    n = 1;
    while (!result_valid && n < 2000) begin
      @(negedge clk);
      n++;
      cfg_wr = (n == per(1, 7) * 4); cfg_os = (n == per(1, 7) * 4);
    end
    cfg_wr = 1'b0; cfg_os = 1'b0;
    chk(n == per(1, 7) * 4 + 1, "R3", "latency with collision write", n, per(1, 7) * 4 + 1);
    idle_for(50, "R3");

    // R8: power-down on the completing cycle suppresses the result.
    phase = "R8";
    cfg(1'b1, 1'b1, 3'd7);
    n = 1;
    while (!result_valid && n < 300) begin
      @(negedge clk);
      n++;
      cfg1_wr = (n == per(1, 7) * 4); cfg1_pd = (n == per(1, 7) * 4);
    end
    cfg1_wr = 1'b0; cfg1_pd = 1'b0;
    chk(n == 300, "R8", "result suppressed by power-down", n, 300);
    chk(os_status === 1'b1, "R8", "idle after power-down", int'(os_status), 1);
    cfg(1'b1, 1'b1, 3'd7);
    wait_rv(n, 2000);
    chk(n == per(1, 7) * 4 + 1, "R8", "start after self-clear", n, per(1, 7) * 4 + 1);

    // R7: continuous mode, result every period.
    phase = "R7";
    cfg(1'b0, 1'b0, 3'd7);
    wait_rv(n, 2000);
    chk(n == per(1, 7) + 1, "R7", "first continuous result", n, per(1, 7) + 1);
    next_gap(n);
    chk(n == per(1, 7), "R7", "continuous interval", n, per(1, 7));
    chk(os_status === 1'b0, "R7", "busy in continuous", int'(os_status), 0);

    // R10: rate change mid-period applies at the next period.
    phase = "R10";
    repeat (5) @(negedge clk);
    cfg(1'b0, 1'b0, 3'd6);
    next_gap(n);
    next_gap(n);
    chk(n == per(1, 6), "R10", "new interval after rate write", n, per(1, 6));

    // R8: power-down during continuous.
    phase = "R8";
    cfg1(1'b1, 1'b1);
    idle_for(150, "R8");

    // R9: mode switches.
    phase = "R9";
    cfg(1'b0, 1'b0, 3'd7);
    repeat (7) @(negedge clk);
    cfg(1'b1, 1'b0, 3'd7);
    idle_for(60, "R9");
    cfg(1'b1, 1'b1, 3'd7);
    repeat (10) @(negedge clk);
    cfg(1'b0, 1'b0, 3'd5);
    wait_rv(n, 2000);
    chk(n == per(1, 5) + 1, "R9", "fresh continuous after switch", n, per(1, 5) + 1);
    repeat (9) @(negedge clk);
    cfg(1'b1, 1'b1, 3'd7);
    wait_rv(n, 2000);
    chk(n == per(1, 7) * 4 + 1, "R9", "fresh single after switch", n, per(1, 7) * 4 + 1);

    // R6: ticks on alternate cycles only.
    phase = "R6";
    gap_mode = 1'b1;
    cfg1(1'b0, 1'b0);
    cfg(1'b1, 1'b1, 3'd7);
    wait_rv(n, 3000);
    chk(n >= per(0, 7) * 8 && n <= per(0, 7) * 8 + 1, "R6", "latency with tick gaps",
        n, per(0, 7) * 8);
    gap_mode = 1'b0;
    repeat (20) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule